// File: doc/BRIEF.md
# Multi-Warp Issue Scheduler

This block lives inside one compute core and keeps the scheduling state of a pool of warp contexts (48 by default). A context is claimed for a thread block by an allocation event, which records the block slot and the lane mask of the threads that are active in the warp. After that, the surrounding pipeline reports four kinds of event: a warp started waiting on memory, a memory response came back, a warp arrived at its block's barrier, and a warp terminated.

In every cycle the scheduler offers up to two different runnable warps for instruction issue. The two warps may belong to different blocks. A round-robin pointer that follows the last granted warp orders the search, so no runnable warp is passed over indefinitely. A barrier opens for a block when every one of its live warps has arrived, and all of them become runnable again at the same time. When every warp of a block has terminated, the scheduler gives a one-cycle done pulse naming the block slot, and in the same step it frees all contexts of that block for reuse.

Top module: `warp_issue_sched`

## Requirements
- R1: While reset is asserted and right after it, no issue grant and no done pulse is given, and the round-robin pointer starts so that context 0 is searched first.
- R2: A context is runnable only if it is allocated, has not exited, has no memory wait pending and is not held at a barrier. Only runnable contexts are ever granted.
- R3: At most two grants are given per cycle. Slot 1 is valid only when slot 0 is valid, and the two never name the same context.
- R4: Slot 0 grants the first runnable context after the pointer, searching upward with wrap-around. Slot 1 grants the first runnable context after slot 0's choice. The pointer then moves to slot 1's context if that slot is valid, otherwise to slot 0's, and it holds when nothing is granted. Grants change one cycle after the events that cause them.
- R5: A memory-wait set event makes a context non-runnable until a clear event arrives for it. If a set and a clear for the same context come in the same cycle, the clear takes effect.
- R6: A live context that arrives at a barrier stays non-runnable until every live context of its block has arrived. All of them are then released in the same cycle.
- R7: Exited contexts do not count toward barrier completion. The exit of the last context that had not arrived releases the ones that are waiting.
- R8: When every allocated context of a block slot has exited, done_valid pulses for exactly one cycle with done_block set to that slot, and the block's contexts become unallocated.
- R9: A context whose lane mask has fewer than all lanes set is still scheduled as one warp. Each grant carries the lane mask that was recorded at allocation.
- R10: The two grants of one cycle may name contexts that belong to different block slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Claim a context for a block |
| alloc_warp | input | $clog2(NUM_WARPS) | Context being claimed |
| alloc_block | input | $clog2(NUM_BLOCKS) | Block slot that owns the context |
| alloc_lanes | input | LANES | Active-lane mask of the warp |
| mem_set_valid | input | 1 | Context starts waiting on memory |
| mem_set_warp | input | $clog2(NUM_WARPS) | Context for the set event |
| mem_clr_valid | input | 1 | Memory response for a context |
| mem_clr_warp | input | $clog2(NUM_WARPS) | Context for the clear event |
| bar_valid | input | 1 | Context arrives at its block barrier |
| bar_warp | input | $clog2(NUM_WARPS) | Arriving context |
| exit_valid | input | 1 | Context terminates |
| exit_warp | input | $clog2(NUM_WARPS) | Terminating context |
| issue0_valid | output | 1 | First grant valid |
| issue0_warp | output | $clog2(NUM_WARPS) | First granted context |
| issue0_lanes | output | LANES | Lane mask of first grant |
| issue1_valid | output | 1 | Second grant valid |
| issue1_warp | output | $clog2(NUM_WARPS) | Second granted context |
| issue1_lanes | output | LANES | Lane mask of second grant |
| done_valid | output | 1 | Block finished pulse |
| done_block | output | $clog2(NUM_BLOCKS) | Block slot that finished |

## Verification
The bench builds the scheduler with 8 contexts, 4 block slots and 4 lanes. At that size a few thousand cycles of mixed events carry the round-robin pointer through every wrap position many times. They also fill and drain every block slot repeatedly, and they hit barriers that are completed by arrivals and barriers that are completed by exits. A cycle-level model written from the requirements predicts both grant slots, their lane masks and the done pulse in every cycle. Directed phases before the sweep cover the partial lane mask, the set-and-clear collision, barrier hold and release, and block completion.

// File: rtl/wsched_pkg.sv
package wsched_pkg;
  // Advance a context index by a step and wrap inside a pool of n entries.
  function automatic int wrap_step(input int base, input int step, input int n);
    int r;
    r = base + step;
    if (r >= n) r = r - n;
    return r;
  endfunction
endpackage

// File: rtl/wsched_rr_pick.sv
module wsched_rr_pick #(
  parameter int N  = 48,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic          hit,
  output logic [IW-1:0] sel
);
  // Search starts one above last and wraps; last itself is tried last.
  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int i = 1; i <= N; i++) begin
      automatic int p = wsched_pkg::wrap_step(int'(last), i, N);
      if (!hit && req[IW'(p)]) begin
        hit = 1'b1;
        sel = IW'(p);
      end
    end
  end
endmodule

// File: rtl/wsched_blk_track.sv
module wsched_blk_track #(
  parameter int NW = 48,
  parameter int NB = 8,
  parameter int BW = $clog2(NB)
) (
  input  logic [NW-1:0]         ctx_valid,
  input  logic [NW-1:0]         ctx_exited,
  input  logic [NW-1:0]         ctx_wait_bar,
  input  logic [NW-1:0][BW-1:0] ctx_blk,
  output logic [NB-1:0]         bar_release,
  output logic                  done_hit,
  output logic [BW-1:0]         done_id
);
  logic [NB-1:0] has_member, has_live, has_lagger;

  always_comb begin
    has_member = '0;
    has_live   = '0;
    has_lagger = '0;
    for (int b = 0; b < NB; b++) begin
      for (int w = 0; w < NW; w++) begin
        if (ctx_valid[w] && ctx_blk[w] == BW'(b)) begin
          has_member[b] = 1'b1;
          if (!ctx_exited[w]) begin
            has_live[b] = 1'b1;
            if (!ctx_wait_bar[w]) has_lagger[b] = 1'b1;
          end
        end
      end
    end
  end

  // Barrier opens when the block has live warps and none still outside it.
  assign bar_release = has_live & ~has_lagger;

  // Lowest finished block slot is reported first.
  always_comb begin
    done_hit = 1'b0;
    done_id  = '0;
    for (int b = NB - 1; b >= 0; b--) begin
      if (has_member[b] && !has_live[b]) begin
        done_hit = 1'b1;
        done_id  = BW'(b);
      end
    end
  end
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
  parameter int NUM_WARPS  = 48,
  parameter int NUM_BLOCKS = 8,
  parameter int LANES      = 32,
  localparam int WW = $clog2(NUM_WARPS),
  localparam int BW = $clog2(NUM_BLOCKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_valid,
  input  logic [WW-1:0]    alloc_warp,
  input  logic [BW-1:0]    alloc_block,
  input  logic [LANES-1:0] alloc_lanes,
  input  logic             mem_set_valid,
  input  logic [WW-1:0]    mem_set_warp,
  input  logic             mem_clr_valid,
  input  logic [WW-1:0]    mem_clr_warp,
  input  logic             bar_valid,
  input  logic [WW-1:0]    bar_warp,
  input  logic             exit_valid,
  input  logic [WW-1:0]    exit_warp,
  output logic             issue0_valid,
  output logic [WW-1:0]    issue0_warp,
  output logic [LANES-1:0] issue0_lanes,
  output logic             issue1_valid,
  output logic [WW-1:0]    issue1_warp,
  output logic [LANES-1:0] issue1_lanes,
  output logic             done_valid,
  output logic [BW-1:0]    done_block
);
  localparam int NW = NUM_WARPS;

  logic [NW-1:0]         ctx_valid_q, ctx_valid_n;
  logic [NW-1:0]         exited_q, exited_n;
  logic [NW-1:0]         pend_q, pend_n;
  logic [NW-1:0]         bar_q, bar_n;
  logic [NW-1:0][BW-1:0] blk_q;
  logic [LANES-1:0]      lanes_q [NW];
  logic [WW-1:0]         last_q, last_n;
  logic                  last_en;

  logic [NUM_BLOCKS-1:0] bar_release;
  logic                  done_hit;
  logic [BW-1:0]         done_id;
  logic [NW-1:0]         runnable, req_second;
  logic                  hit0, hit1;
  logic [WW-1:0]         sel0, sel1;

  wsched_blk_track #(.NW(NW), .NB(NUM_BLOCKS), .BW(BW)) i_blk_track (
    .ctx_valid   (ctx_valid_q),
    .ctx_exited  (exited_q),
    .ctx_wait_bar(bar_q),
    .ctx_blk     (blk_q),
    .bar_release (bar_release),
    .done_hit    (done_hit),
    .done_id     (done_id)
  );

  assign runnable = ctx_valid_q & ~exited_q & ~pend_q & ~bar_q;

  always_comb begin
    req_second = runnable;
    if (hit0) req_second[sel0] = 1'b0;
  end

  wsched_rr_pick #(.N(NW), .IW(WW)) i_pick0 (
    .req(runnable), .last(last_q), .hit(hit0), .sel(sel0)
  );
  wsched_rr_pick #(.N(NW), .IW(WW)) i_pick1 (
    .req(req_second), .last(sel0), .hit(hit1), .sel(sel1)
  );

  assign issue0_valid = hit0;
  assign issue0_warp  = sel0;
  assign issue0_lanes = lanes_q[sel0];
  assign issue1_valid = hit0 && hit1;
  assign issue1_warp  = sel1;
  assign issue1_lanes = lanes_q[sel1];
  assign done_valid   = done_hit;
  assign done_block   = done_id;

  assign last_en = hit0;
  assign last_n  = issue1_valid ? sel1 : sel0;

  // Per-context next state; allocation overrides every other event.
  always_comb begin
    for (int w = 0; w < NW; w++) begin
      automatic logic is_alloc = alloc_valid && alloc_warp == WW'(w);
      automatic logic is_exit  = exit_valid && exit_warp == WW'(w);
      automatic logic is_live  = ctx_valid_q[w] && !exited_q[w];
      automatic logic freed    = done_hit && ctx_valid_q[w] && blk_q[w] == done_id;
      ctx_valid_n[w] = ctx_valid_q[w] && !freed;
      exited_n[w]    = (exited_q[w] || (is_exit && is_live)) && !freed;
      pend_n[w]      = pend_q[w];
      if (mem_set_valid && mem_set_warp == WW'(w)) pend_n[w] = 1'b1;
      if (mem_clr_valid && mem_clr_warp == WW'(w)) pend_n[w] = 1'b0;
      bar_n[w] = bar_q[w] && !bar_release[blk_q[w]];
      if (bar_valid && bar_warp == WW'(w) && is_live) bar_n[w] = 1'b1;
      if (is_exit) bar_n[w] = 1'b0;
      if (is_alloc) begin
        ctx_valid_n[w] = 1'b1;
        exited_n[w]    = 1'b0;
        pend_n[w]      = 1'b0;
        bar_n[w]       = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_valid_q <= '0;
      exited_q    <= '0;
      pend_q      <= '0;
      bar_q       <= '0;
      last_q      <= WW'(NW - 1);
    end else begin
      ctx_valid_q <= ctx_valid_n;
      exited_q    <= exited_n;
      pend_q      <= pend_n;
      bar_q       <= bar_n;
      if (last_en) last_q <= last_n;
    end
  end

  // Block tag and lane mask are plain data, loaded only on allocation.
  always_ff @(posedge clk) begin
    for (int w = 0; w < NW; w++) begin
      if (alloc_valid && alloc_warp == WW'(w)) begin
        blk_q[w]   <= alloc_block;
        lanes_q[w] <= alloc_lanes;
      end
    end
  end

  AST_TWO_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
    issue1_valid |-> issue0_valid && issue1_warp != issue0_warp); // R3

  AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    issue0_valid |-> ctx_valid_q[issue0_warp] && !exited_q[issue0_warp]
                     && !pend_q[issue0_warp] && !bar_q[issue0_warp]); // R2

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_set_valid && mem_clr_valid && mem_set_warp == mem_clr_warp && !alloc_valid
    |=> !pend_q[$past(mem_clr_warp)]); // R5

  AST_DONE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !(done_valid && done_block == $past(done_block))); // R8

  AST_POINTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !issue0_valid |=> $stable(last_q)); // R4
endmodule

// File: tb/test_warp_issue_sched.sv
module test_warp_issue_sched;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 8;
  localparam int NB = 4;
  localparam int LN = 4;
  localparam int WW = $clog2(NW);
  localparam int BW = $clog2(NB);

  logic clk = 1'b0;
  logic rst_n;
  logic alloc_valid, mem_set_valid, mem_clr_valid, bar_valid, exit_valid;
  logic [WW-1:0] alloc_warp, mem_set_warp, mem_clr_warp, bar_warp, exit_warp;
  logic [BW-1:0] alloc_block;
  logic [LN-1:0] alloc_lanes;
  logic issue0_valid, issue1_valid, done_valid;
  logic [WW-1:0] issue0_warp, issue1_warp;
  logic [LN-1:0] issue0_lanes, issue1_lanes;
  logic [BW-1:0] done_block;

  always #(CLK_PERIOD / 2) clk = ~clk;

  warp_issue_sched #(.NUM_WARPS(NW), .NUM_BLOCKS(NB), .LANES(LN)) i_warp_issue_sched (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_warp(alloc_warp), .alloc_block(alloc_block),
    .alloc_lanes(alloc_lanes),
    .mem_set_valid(mem_set_valid), .mem_set_warp(mem_set_warp),
    .mem_clr_valid(mem_clr_valid), .mem_clr_warp(mem_clr_warp),
    .bar_valid(bar_valid), .bar_warp(bar_warp),
    .exit_valid(exit_valid), .exit_warp(exit_warp),
    .issue0_valid(issue0_valid), .issue0_warp(issue0_warp), .issue0_lanes(issue0_lanes),
    .issue1_valid(issue1_valid), .issue1_warp(issue1_warp), .issue1_lanes(issue1_lanes),
    .done_valid(done_valid), .done_block(done_block)
  );

  int errors = 0;
  int checks = 0;
  int diff_blk = 0;
  string tag = "R1";

  // Model state
  bit m_valid [NW];
  bit m_exit  [NW];
  bit m_pend  [NW];
  bit m_bar   [NW];
  int m_blk   [NW];
  logic [LN-1:0] m_lanes [NW];
  int m_last;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic int pick(input logic [NW-1:0] req, input int last);
    for (int i = 1; i <= NW; i++) begin
      int p;
      p = (last + i) % NW;
      if (req[p]) return p;
    end
    return -1;
  endfunction

  task automatic clear_inputs();
    alloc_valid = 0; mem_set_valid = 0; mem_clr_valid = 0; bar_valid = 0; exit_valid = 0;
    alloc_warp = '0; alloc_block = '0; alloc_lanes = '0; mem_set_warp = '0;
    mem_clr_warp = '0; bar_warp = '0; exit_warp = '0;
  endtask

  task automatic ev_alloc(input int w, input int b, input logic [LN-1:0] l);
    alloc_valid = 1; alloc_warp = WW'(w); alloc_block = BW'(b); alloc_lanes = l;
  endtask
  task automatic ev_set(input int w);  mem_set_valid = 1; mem_set_warp = WW'(w); endtask
  task automatic ev_clr(input int w);  mem_clr_valid = 1; mem_clr_warp = WW'(w); endtask
  task automatic ev_bar(input int w);  bar_valid = 1; bar_warp = WW'(w); endtask
  task automatic ev_exit(input int w); exit_valid = 1; exit_warp = WW'(w); endtask

  // One cycle: compare outputs (state only) against the model, advance model, clock.
  task automatic cyc();
    logic [NW-1:0] run, req2;
    int e0, e1, dblk;
    bit member [NB];
    bit live [NB];
    bit lag [NB];
    bit rel [NB];
    for (int w = 0; w < NW; w++) run[w] = m_valid[w] && !m_exit[w] && !m_pend[w] && !m_bar[w];
    e0 = pick(run, m_last);
    req2 = run;
    if (e0 >= 0) req2[e0] = 1'b0;
    e1 = (e0 >= 0) ? pick(req2, e0) : -1;
    for (int b = 0; b < NB; b++) begin member[b] = 0; live[b] = 0; lag[b] = 0; end
    for (int w = 0; w < NW; w++) if (m_valid[w]) begin
      member[m_blk[w]] = 1;
      if (!m_exit[w]) begin
        live[m_blk[w]] = 1;
        if (!m_bar[w]) lag[m_blk[w]] = 1;
      end
    end
    dblk = -1;
    for (int b = NB - 1; b >= 0; b--) begin
      rel[b] = live[b] && !lag[b];
      if (member[b] && !live[b]) dblk = b;
    end
    // R2 R3 R4 R9 grant slot 0
    check(issue0_valid == (e0 >= 0) &&
          (e0 < 0 || (int'(issue0_warp) == e0 && issue0_lanes == m_lanes[e0])),
          "grant0 {valid,warp,lanes}",
          issue0_valid ? (int'(issue0_warp) * 16 + int'(issue0_lanes)) : -1,
          (e0 >= 0) ? (e0 * 16 + int'(m_lanes[e0])) : -1);
    // R3 R4 R9 grant slot 1
    check(issue1_valid == (e1 >= 0) &&
          (e1 < 0 || (int'(issue1_warp) == e1 && issue1_lanes == m_lanes[e1])),
          "grant1 {valid,warp,lanes}",
          issue1_valid ? (int'(issue1_warp) * 16 + int'(issue1_lanes)) : -1,
          (e1 >= 0) ? (e1 * 16 + int'(m_lanes[e1])) : -1);
    // R8 done pulse
    check(done_valid == (dblk >= 0) && (dblk < 0 || int'(done_block) == dblk),
          "done {valid,block}", done_valid ? int'(done_block) : -1, dblk);
    if (e0 >= 0 && e1 >= 0 && m_blk[e0] != m_blk[e1]) diff_blk++;
    // advance model
    for (int w = 0; w < NW; w++) begin
      bit live_w, freed, is_exit;
      live_w  = m_valid[w] && !m_exit[w];
      freed   = dblk >= 0 && m_valid[w] && m_blk[w] == dblk;
      is_exit = exit_valid && int'(exit_warp) == w;
      m_exit[w]  = (m_exit[w] || (is_exit && live_w)) && !freed;
      if (mem_set_valid && int'(mem_set_warp) == w) m_pend[w] = 1;
      if (mem_clr_valid && int'(mem_clr_warp) == w) m_pend[w] = 0;
      m_bar[w] = m_bar[w] && !rel[m_blk[w]];
      if (bar_valid && int'(bar_warp) == w && live_w) m_bar[w] = 1;
      if (is_exit) m_bar[w] = 0;
      m_valid[w] = m_valid[w] && !freed;
      if (alloc_valid && int'(alloc_warp) == w) begin
        m_valid[w] = 1; m_exit[w] = 0; m_pend[w] = 0; m_bar[w] = 0;
        m_blk[w] = int'(alloc_block); m_lanes[w] = alloc_lanes;
      end
    end
    if (e1 >= 0) m_last = e1;
    else if (e0 >= 0) m_last = e0;
    @(posedge clk);
    @(negedge clk);
    clear_inputs();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] rnd;
    clear_inputs();
    rst_n = 0;
    for (int w = 0; w < NW; w++) begin
      m_valid[w] = 0; m_exit[w] = 0; m_pend[w] = 0; m_bar[w] = 0; m_blk[w] = 0; m_lanes[w] = '0;
    end
    m_last = NW - 1;
    repeat (3) @(negedge clk);
    tag = "R1";
    check(!issue0_valid && !issue1_valid, "grant during reset", int'(issue0_valid), 0);
    check(!done_valid, "done during reset", int'(done_valid), 0);
    rst_n = 1;
    cyc(); cyc();

    // R9: partial lane masks; blocks 0,1,2
    tag = "R9";
    ev_alloc(0, 0, 4'b1111); cyc();
    ev_alloc(1, 0, 4'b1111); cyc();
    ev_alloc(2, 0, 4'b0111); cyc();
    ev_alloc(3, 1, 4'b1111); cyc();
    ev_alloc(4, 1, 4'b0001); cyc();
    ev_alloc(5, 2, 4'b0011); cyc();
    tag = "R4";
    repeat (8) cyc();

    // R5: memory wait, then set and clear together
    tag = "R5";
    ev_set(1); cyc();
    ev_set(3); cyc();
    repeat (3) cyc();
    ev_set(1); ev_clr(1); cyc();
    cyc();
    ev_clr(3); cyc();
    repeat (2) cyc();

    // R6: block 0 barrier completed by arrivals
    tag = "R6";
    ev_bar(0); cyc();
    ev_bar(1); cyc();
    repeat (2) cyc();
    ev_bar(2); cyc();
    repeat (3) cyc();

    // R7: block 1 barrier completed by an exit
    tag = "R7";
    ev_bar(3); cyc();
    repeat (2) cyc();
    ev_exit(4); cyc();
    repeat (2) cyc();

    // R8: blocks finish and free their contexts
    tag = "R8";
    ev_exit(3); cyc();
    repeat (2) cyc();
    ev_exit(0); cyc();
    ev_exit(1); cyc();
    ev_exit(2); cyc();
    cyc();
    ev_exit(5); cyc();
    tag = "R2";
    repeat (3) cyc();

    // R3 R10: mixed-event sweep against the model
    tag = "R3";
    rnd = 32'h1234_5678;
    for (int k = 0; k < 3000; k++) begin
      rnd ^= rnd << 13; rnd ^= rnd >> 17; rnd ^= rnd << 5;
      if (rnd[2:0] < 3'd3) begin
        int s;
        s = int'(rnd[10:8]);
        for (int i = 0; i < NW; i++) begin
          int w;
          w = (s + i) % NW;
          if (!m_valid[w] && !alloc_valid)
            ev_alloc(w, int'(rnd[12:11]), rnd[16:13] | 4'b0001);
        end
      end
      if (rnd[19:17] < 3'd3) ev_set(int'(rnd[22:20]));
      if (rnd[25:23] < 3'd4) ev_clr(int'(rnd[28:26]));
      if (rnd[29] && rnd[3]) ev_bar(int'(rnd[7:5]));
      if (rnd[31:30] == 2'd3 && rnd[4]) ev_exit(int'(rnd[15:13]));
      cyc();
    end
    tag = "R10";
    check(diff_blk > 0, "cycles with grants from two blocks", diff_blk, 1);
    finish_run();
  end
endmodule